// File: doc/BRIEF.md
# Word FIFO to Byte Card Data Engine

This block moves payload between a sixteen-entry FIFO of 32-bit words and a byte-wide card data port. Host logic loads a byte length, then writes a data control word that starts the transfer and picks its direction. In the card-to-FIFO direction, bytes taken from the card are packed into words in little-endian order. A trailing partial word is pushed once the byte budget runs out. In the FIFO-to-card direction, words are popped and sent to the card least significant byte first.

A byte down-counter tracks the remaining budget. When it reaches zero, two sticky end flags are raised. The engine switches itself off once the counter is zero and the FIFO has drained. One set of FIFO level flags is reported, under the receive group of status bits or the transmit group, depending on the direction. Both card-side channels use a valid/ready handshake and move at most one byte per clock.

The controller is a state machine with five named states:
- `S_IDLE`: disabled.
- `S_RX`: taking bytes from the card.
- `S_TX_FETCH`: waiting for a word to pop.
- `S_TX_SEND`: shifting the held word out byte by byte.
- `S_DRAIN`: the budget is spent and the engine waits for an empty FIFO.

The transitions are:
- A start goes from any state to `S_RX`, `S_TX_FETCH` or, with a zero length, `S_DRAIN`.
- A stop goes from any state to `S_IDLE`.
- `S_RX` goes to `S_DRAIN` on its last byte.
- `S_TX_FETCH` goes to `S_TX_SEND` when a word is available.
- `S_TX_SEND` goes back to `S_TX_FETCH` after the fourth byte of a word, or to `S_DRAIN` on the last byte.
- `S_DRAIN` goes to `S_IDLE` when the FIFO level is zero.

Top module: `card_xfer_engine`

## Requirements
- R1: After reset, xfer_enable, byte_count, fifo_level, status, card_rx_ready and card_tx_valid are all zero.
- R2: A ctl_we pulse with ctl_in[0]=1 starts a transfer. It copies the 16-bit length last written through len_we into byte_count and raises xfer_enable. ctl_in[1]=1 selects card-to-FIFO and 0 selects FIFO-to-card. A ctl_we pulse with ctl_in[0]=0 stops the engine.
- R3: In card-to-FIFO mode, the first byte of each group of four lands in word bits [7:0] and the fourth in [31:24]. A word enters the FIFO as its fourth byte is taken.
- R4: When the byte budget ends inside a word, that partial word is pushed with its unfilled upper bytes zero.
- R5: card_rx_ready stays low while fifo_level is 16, so the FIFO never exceeds 16 words.
- R6: In FIFO-to-card mode, each word is sent bits [7:0] first and bits [31:24] last. card_tx_valid drops when the FIFO is empty and no byte of the current word remains. Bytes of a word beyond the budget are discarded.
- R7: byte_count decreases by exactly one per completed card handshake, and it holds otherwise.
- R8: When byte_count reaches zero, status bit 8 (data end) and bit 10 (block end) are set. They stay set until end_clr[0] or end_clr[1] respectively is pulsed.
- R9: Once byte_count is zero and the FIFO is empty, xfer_enable clears and all FIFO flag bits (status[21:12]) read zero.
- R10: While the engine is enabled, the FIFO flags follow fifo_level: active, empty (level 0), data available (level not 0), full (level 16), half-empty (level at most 8), half-full (level at least 8). Card-to-FIFO uses bits 13, 19, 21, 17, 15 for active, empty, available, full and half-full. FIFO-to-card uses bits 12, 18, 20, 16, 14 for active, empty, available, full and half-empty. The other group stays zero.
- R11: host_pop_data reads zero and fifo_level is unchanged when the FIFO is empty. A host push is ignored while byte_count is zero.
- R12: A card-to-FIFO transfer takes no byte while card_rx_valid is low. byte_count holds until the card offers data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_we | input | 1 | Load the byte length |
| len_in | input | LEN_W | Byte length value |
| ctl_we | input | 1 | Write data control (start or stop) |
| ctl_in | input | 2 | Bit 0 enable, bit 1 direction (1 = card to FIFO) |
| end_clr | input | 2 | Bit 0 clears data end, bit 1 clears block end |
| host_push_valid | input | 1 | Host writes a word into the FIFO |
| host_push_data | input | WORD_W | Word written by the host |
| host_pop_req | input | 1 | Host takes the head word |
| host_pop_data | output | WORD_W | Head word, zero when the FIFO is empty |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | BYTE_W | Byte from the card |
| card_rx_ready | output | 1 | Engine takes the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | BYTE_W | Byte to the card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| xfer_enable | output | 1 | Transfer engine enabled |
| xfer_dir | output | 1 | Current direction, 1 = card to FIFO |
| byte_count | output | LEN_W | Remaining byte budget |
| fifo_level | output | LVL_W | Words held in the FIFO |
| status | output | 22 | End flags and FIFO flag groups |

## Verification
On every cycle, the bound checker enforces several properties:
- The one-byte-per-handshake countdown and the hold of the count between handshakes.
- The bound on FIFO occupancy and the refusal of card bytes at a full FIFO.
- The stability of an offered transmit byte.
- The raising of both end flags at the moment the count reaches zero.
- The exclusive receive and transmit flag groups, and the all-zero flags when disabled.

Byte ordering within words, the flushing of a partial final word, the discarding of surplus transmit bytes and the exact flag values at each FIFO level need known payloads. Those are shown only by the bench. Its sweeps over every length from 0 to 40 in both directions, with and without handshake gaps, compute each expected word and byte arithmetically.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_TX_FETCH,
        S_TX_SEND,
        S_DRAIN
    } xfer_state_e;

    localparam int STAT_W      = 22;
    localparam int CTL_EN      = 0;
    localparam int CTL_DIR     = 1;

    localparam int ST_DATA_END = 8;
    localparam int ST_BLK_END  = 10;
    localparam int ST_TX_ACT   = 12;
    localparam int ST_RX_ACT   = 13;
    localparam int ST_TX_HALF  = 14;
    localparam int ST_RX_HALF  = 15;
    localparam int ST_TX_FULL  = 16;
    localparam int ST_RX_FULL  = 17;
    localparam int ST_TX_EMPTY = 18;
    localparam int ST_RX_EMPTY = 19;
    localparam int ST_TX_AVAIL = 20;
    localparam int ST_RX_AVAIL = 21;

endpackage

// File: rtl/xfer_word_fifo.sv
module xfer_word_fifo #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (level != LVL_W'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign wr_ptr  = rd_ptr + PTR_W'(level);
    assign head    = (level != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_pop) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/xfer_byte_packer.sv
module xfer_byte_packer #(
    parameter  int WORD_W = 32,
    parameter  int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              last,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_push
);

    logic [WORD_W-1:0] acc;
    logic [LANE_W-1:0] fill;

    always_comb begin
        word_out = acc;
        for (int i = 0; i < LANES; i++) begin
            if (LANE_W'(i) == fill) begin
                word_out[i*BYTE_W +: BYTE_W] = byte_in;
            end
        end
    end

    assign word_push = take && ((fill == LANE_W'(LANES - 1)) || last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            fill <= '0;
        end else if (clr || word_push) begin
            acc  <= '0;
            fill <= '0;
        end else if (take) begin
            acc  <= word_out;
            fill <= fill + LANE_W'(1);
        end
    end

endmodule

// File: rtl/xfer_byte_unpacker.sv
module xfer_byte_unpacker #(
    parameter  int WORD_W = 32,
    parameter  int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LEFT_W = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              send,
    output logic [BYTE_W-1:0] byte_out,
    output logic [LEFT_W-1:0] left
);

    logic [WORD_W-1:0] hold;

    assign byte_out = hold[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            left <= '0;
        end else if (clr) begin
            hold <= '0;
            left <= '0;
        end else if (load) begin
            hold <= load_word;
            left <= LEFT_W'(LANES);
        end else if (send && (left != '0)) begin
            hold <= hold >> BYTE_W;
            left <= left - LEFT_W'(1);
        end
    end

endmodule

// File: rtl/xfer_flag_gen.sv
module xfer_flag_gen
    import xfer_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              active,
    input  logic              dir_rx,
    input  logic [LVL_W-1:0]  level,
    output logic [STAT_W-1:0] flags
);

    logic is_empty;
    logic is_full;

    assign is_empty = (level == '0);
    assign is_full  = (level == LVL_W'(DEPTH));

    always_comb begin
        flags = '0;
        if (active) begin
            if (dir_rx) begin
                flags[ST_RX_ACT]   = 1'b1;
                flags[ST_RX_EMPTY] = is_empty;
                flags[ST_RX_AVAIL] = !is_empty;
                flags[ST_RX_FULL]  = is_full;
                flags[ST_RX_HALF]  = (level >= LVL_W'(DEPTH / 2));
            end else begin
                flags[ST_TX_ACT]   = 1'b1;
                flags[ST_TX_EMPTY] = is_empty;
                flags[ST_TX_AVAIL] = !is_empty;
                flags[ST_TX_FULL]  = is_full;
                flags[ST_TX_HALF]  = (level <= LVL_W'(DEPTH / 2));
            end
        end
    end

endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine
    import xfer_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int WORD_W = 32,
    parameter  int BYTE_W = 8,
    parameter  int LEN_W  = 16,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LEFT_W = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_in,
    input  logic [1:0]        end_clr,
    input  logic              host_push_valid,
    input  logic [WORD_W-1:0] host_push_data,
    input  logic              host_pop_req,
    output logic [WORD_W-1:0] host_pop_data,
    input  logic              card_rx_valid,
    input  logic [BYTE_W-1:0] card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [BYTE_W-1:0] card_tx_data,
    input  logic              card_tx_ready,
    output logic              xfer_enable,
    output logic              xfer_dir,
    output logic [LEN_W-1:0]  byte_count,
    output logic [LVL_W-1:0]  fifo_level,
    output logic [STAT_W-1:0] status
);

    xfer_state_e state_q, state_d;

    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic              dir_q;
    logic              dend_q;
    logic              bend_q;

    logic              start, stop, count_is_one;
    logic              rx_take, tx_send, tx_load;
    logic              host_push_ok, host_pop_ok;
    logic              fifo_push, fifo_pop;
    logic [WORD_W-1:0] fifo_wdata, fifo_head;
    logic [WORD_W-1:0] pack_word;
    logic              pack_push, pack_clr;
    logic              unpack_clr;
    logic [BYTE_W-1:0] unpack_byte;
    logic [LEFT_W-1:0] unpack_left;
    logic [STAT_W-1:0] fifo_flags;
    logic              set_end;

    assign start        = ctl_we && ctl_in[CTL_EN];
    assign stop         = ctl_we && !ctl_in[CTL_EN];
    assign count_is_one = (cnt_q == LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = S_IDLE;
        end else if (start) begin
            if (len_q == '0) begin
                state_d = S_DRAIN;
            end else if (ctl_in[CTL_DIR]) begin
                state_d = S_RX;
            end else begin
                state_d = S_TX_FETCH;
            end
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_RX: begin
                    if (rx_take && count_is_one) begin
                        state_d = S_DRAIN;
                    end
                end
                S_TX_FETCH: begin
                    if (fifo_level != '0) begin
                        state_d = S_TX_SEND;
                    end
                end
                S_TX_SEND: begin
                    if (tx_send) begin
                        if (count_is_one) begin
                            state_d = S_DRAIN;
                        end else if (unpack_left == LEFT_W'(1)) begin
                            state_d = S_TX_FETCH;
                        end
                    end
                end
                S_DRAIN: begin
                    if (fifo_level == '0) begin
                        state_d = S_IDLE;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath steering
    always_comb begin
        card_rx_ready = (state_q == S_RX) && (fifo_level != LVL_W'(DEPTH));
        rx_take       = card_rx_valid && card_rx_ready;
        card_tx_valid = (state_q == S_TX_SEND);
        card_tx_data  = unpack_byte;
        tx_send       = card_tx_valid && card_tx_ready;
        tx_load       = (state_q == S_TX_FETCH) && (fifo_level != '0);
        host_push_ok  = host_push_valid && !dir_q && (state_q != S_IDLE) && (cnt_q != '0);
        host_pop_ok   = host_pop_req && dir_q;
        fifo_push     = dir_q ? pack_push : host_push_ok;
        fifo_wdata    = dir_q ? pack_word : host_push_data;
        fifo_pop      = dir_q ? host_pop_ok : tx_load;
        pack_clr      = start || stop;
        unpack_clr    = start || stop || (tx_send && count_is_one);
        xfer_enable   = (state_q != S_IDLE);
        xfer_dir      = dir_q;
        byte_count    = cnt_q;
        host_pop_data = fifo_head;
        status        = fifo_flags;
        status[ST_DATA_END] = dend_q;
        status[ST_BLK_END]  = bend_q;
    end

    assign set_end = (state_d == S_DRAIN) && ((state_q != S_DRAIN) || start);

    // Counter, configuration and sticky end flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            dir_q  <= 1'b0;
            dend_q <= 1'b0;
            bend_q <= 1'b0;
        end else begin
            if (len_we) begin
                len_q <= len_in;
            end
            if (start) begin
                cnt_q <= len_q;
                dir_q <= ctl_in[CTL_DIR];
            end else if (rx_take || tx_send) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
            dend_q <= set_end || (dend_q && !end_clr[0]);
            bend_q <= set_end || (bend_q && !end_clr[1]);
        end
    end

    xfer_word_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (fifo_level)
    );

    xfer_byte_packer #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pack_clr),
        .take      (rx_take),
        .last      (count_is_one),
        .byte_in   (card_rx_data),
        .word_out  (pack_word),
        .word_push (pack_push)
    );

    xfer_byte_unpacker #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (unpack_clr),
        .load      (tx_load),
        .load_word (fifo_head),
        .send      (tx_send),
        .byte_out  (unpack_byte),
        .left      (unpack_left)
    );

    xfer_flag_gen #(
        .DEPTH (DEPTH)
    ) u_flags (
        .active (xfer_enable),
        .dir_rx (dir_q),
        .level  (fifo_level),
        .flags  (fifo_flags)
    );

endmodule

// File: rtl/card_xfer_checker.sv
module card_xfer_checker #(
    parameter  int DEPTH  = 16,
    parameter  int BYTE_W = 8,
    parameter  int LEN_W  = 16,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              card_rx_valid,
    input logic              card_rx_ready,
    input logic              card_tx_valid,
    input logic [BYTE_W-1:0] card_tx_data,
    input logic              card_tx_ready,
    input logic              xfer_enable,
    input logic [LEN_W-1:0]  byte_count,
    input logic [LVL_W-1:0]  fifo_level,
    input logic [21:0]       status
);

    logic rx_hs;
    logic tx_hs;
    assign rx_hs = card_rx_valid && card_rx_ready;
    assign tx_hs = card_tx_valid && card_tx_ready;

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    a_r5_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (fifo_level != LVL_W'(DEPTH)) && (byte_count != '0));

    a_r7_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_hs && !ctl_we) |=> byte_count == $past(byte_count) - LEN_W'(1));

    a_r7_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hs && !ctl_we) |=> byte_count == $past(byte_count) - LEN_W'(1));

    a_r12_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_hs && !tx_hs && !ctl_we) |=> $stable(byte_count));

    a_r6_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (card_tx_valid && !card_tx_ready && !ctl_we) |=> card_tx_valid && $stable(card_tx_data));

    a_r8_end_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_enable && byte_count == '0 && $past(byte_count) != '0) |-> status[8] && status[10]);

    a_r9_self_off: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_enable && byte_count == '0 && fifo_level == '0 && !ctl_we) |=> !xfer_enable);

    a_r9_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_enable |-> status[21:12] == '0);

    a_r10_one_group: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(status & 22'h2AA000)) && (|(status & 22'h155000))));

    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_ready && card_tx_valid));

endmodule

bind card_xfer_engine card_xfer_checker #(
    .DEPTH  (DEPTH),
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_we        (ctl_we),
    .card_rx_valid (card_rx_valid),
    .card_rx_ready (card_rx_ready),
    .card_tx_valid (card_tx_valid),
    .card_tx_data  (card_tx_data),
    .card_tx_ready (card_tx_ready),
    .xfer_enable   (xfer_enable),
    .byte_count    (byte_count),
    .fifo_level    (fifo_level),
    .status        (status)
);

// File: tb/card_xfer_engine_tb.sv
`timescale 1ns/1ps
module card_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_we = 1'b0;
    logic [15:0] len_in = '0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_in = '0;
    logic [1:0]  end_clr = '0;
    logic        host_push_valid = 1'b0;
    logic [31:0] host_push_data = '0;
    logic        host_pop_req = 1'b0;
    logic [31:0] host_pop_data;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        xfer_enable;
    logic        xfer_dir;
    logic [15:0] byte_count;
    logic [4:0]  fifo_level;
    logic [21:0] status;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    card_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_in(len_in),
        .ctl_we(ctl_we), .ctl_in(ctl_in), .end_clr(end_clr),
        .host_push_valid(host_push_valid), .host_push_data(host_push_data),
        .host_pop_req(host_pop_req), .host_pop_data(host_pop_data),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .xfer_enable(xfer_enable), .xfer_dir(xfer_dir),
        .byte_count(byte_count), .fifo_level(fifo_level), .status(status)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(int len, int k);
        return 8'(k * 37 + len * 5 + 1);
    endfunction

    function automatic logic [31:0] rword(int len, int j);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++) begin
            if (4 * j + b < len) w[8*b +: 8] = rpat(len, 4 * j + b);
        end
        return w;
    endfunction

    function automatic logic [31:0] wword(int len, int j);
        return (32'(j + 1) * 32'h9E3779B1) ^ 32'(len);
    endfunction

    // R10 flag encoding computed from level and direction
    function automatic logic [21:0] exp_flags(bit en, bit rx, int lvl);
        logic [21:0] f = '0;
        if (en) begin
            if (rx) begin
                f[13] = 1'b1; f[19] = (lvl == 0); f[21] = (lvl != 0);
                f[17] = (lvl == 16); f[15] = (lvl >= 8);
            end else begin
                f[12] = 1'b1; f[18] = (lvl == 0); f[20] = (lvl != 0);
                f[16] = (lvl == 16); f[14] = (lvl <= 8);
            end
        end
        return f;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start(int len, bit rx);
        len_we = 1'b1; len_in = 16'(len);
        tick();
        len_we = 1'b0; ctl_we = 1'b1; ctl_in = {rx, 1'b1};
        tick();
        ctl_we = 1'b0;
        chk(byte_count == 16'(len), "R2 count load", byte_count, len);
        chk(xfer_enable && xfer_dir == rx, "R2 enable/dir", {xfer_enable, xfer_dir}, {1'b1, rx});
    endtask

    task automatic clear_end();
        end_clr = 2'b01;
        tick();
        chk(!status[8] && status[10], "R8 clear data end only", status, 22'h400);
        end_clr = 2'b10;
        tick();
        end_clr = 2'b00;
        chk(status == '0, "R8 clear block end", status, 0);
    endtask

    task automatic run_read(int len, bit gappy, int hold);
        int k = 0;
        int got = 0;
        int nw = (len + 3) / 4;
        bit r;
        start(len, 1'b1);
        for (int it = 0; it < 4000; it++) begin
            if (k == len && got == nw && !xfer_enable) break;
            if (gappy && it == 3) chk(byte_count == 16'(len), "R12 waits for card", byte_count, len);
            if (hold != 0 && it == hold) begin
                chk(fifo_level == 16, "R5 level at full", fifo_level, 16);
                chk(!card_rx_ready, "R5 ready low when full", card_rx_ready, 0);
                chk(byte_count == 16'(len - 64), "R5 count stalled", byte_count, len - 64);
            end
            chk((status & 22'h3FF000) == exp_flags(xfer_enable, 1'b1, int'(fifo_level)),
                "R10 rx flags", status & 22'h3FF000, exp_flags(xfer_enable, 1'b1, int'(fifo_level)));
            card_rx_valid = (k < len) && !(gappy && (it < 3 || it % 3 == 0));
            card_rx_data  = rpat(len, k);
            host_pop_req  = (it >= hold) && (fifo_level != 0);
            if (host_pop_req) begin
                if (got == nw - 1 && len % 4 != 0)
                    chk(host_pop_data == rword(len, got), "R4 partial word", host_pop_data, rword(len, got));
                else
                    chk(host_pop_data == rword(len, got), "R3 packed word", host_pop_data, rword(len, got));
                got++;
            end
            r = card_rx_ready;
            tick();
            if (card_rx_valid && r) k++;
        end
        card_rx_valid = 1'b0;
        host_pop_req  = 1'b0;
        chk(!xfer_enable && k == len && got == nw, "R9 read done", {xfer_enable, 8'(got)}, nw);
        chk(byte_count == 0, "R7 count at zero", byte_count, 0);
        chk(status == 22'h000500, "R8 end flags after read", status, 22'h500);
        clear_end();
    endtask

    task automatic run_write(int len, bit gappy);
        int k = 0;
        int pushed = 0;
        int nw = (len + 3) / 4;
        bit v;
        logic [7:0] d;
        logic [31:0] w;
        start(len, 1'b0);
        for (int it = 0; it < 4000; it++) begin
            if (k == len && pushed == nw && !xfer_enable) break;
            chk((status & 22'h3FF000) == exp_flags(xfer_enable, 1'b0, int'(fifo_level)),
                "R10 tx flags", status & 22'h3FF000, exp_flags(xfer_enable, 1'b0, int'(fifo_level)));
            host_push_valid = (pushed < nw) && (fifo_level != 16);
            host_push_data  = wword(len, pushed);
            card_tx_ready   = !(gappy && it % 2 == 0);
            v = card_tx_valid;
            d = card_tx_data;
            if (v && card_tx_ready) begin
                w = wword(len, k / 4);
                if (k >= len) chk(1'b0, "R6 extra byte", k, len);
                else chk(d == w[8*(k%4) +: 8], "R6 byte order", d, w[8*(k%4) +: 8]);
            end
            tick();
            if (host_push_valid) pushed++;
            if (v && card_tx_ready) k++;
        end
        host_push_valid = 1'b0;
        card_tx_ready   = 1'b0;
        chk(!xfer_enable && k == len, "R9 write done", {xfer_enable, 8'(k)}, len);
        chk(byte_count == 0 && fifo_level == 0, "R7 write count zero", byte_count, 0);
        chk(status == 22'h000500, "R8 end flags after write", status, 22'h500);
        clear_end();
    endtask

    task automatic underrun_case();
        logic [7:0] seen [6];
        int k = 0;
        logic [31:0] wa = 32'hA1B2C3D4;
        logic [31:0] wb = 32'h55667788;
        start(6, 1'b0);
        host_push_valid = 1'b1; host_push_data = wa;
        tick();
        host_push_valid = 1'b0;
        card_tx_ready = 1'b1;
        for (int it = 0; it < 20; it++) begin
            if (card_tx_valid && k < 6) begin seen[k] = card_tx_data; k++; end
            tick();
        end
        chk(k == 4, "R6 stops at empty", k, 4);
        chk(!card_tx_valid && byte_count == 2 && xfer_enable, "R6 idle wait", byte_count, 2);
        host_push_valid = 1'b1; host_push_data = wb;
        tick();
        host_push_valid = 1'b0;
        for (int it = 0; it < 20; it++) begin
            if (card_tx_valid && k < 6) begin seen[k] = card_tx_data; k++; end
            tick();
        end
        card_tx_ready = 1'b0;
        for (int b = 0; b < 4; b++) chk(seen[b] == wa[8*b +: 8], "R6 first word", seen[b], wa[8*b +: 8]);
        chk(seen[4] == wb[7:0] && seen[5] == wb[15:8], "R6 tail bytes", {seen[4], seen[5]}, {wb[7:0], wb[15:8]});
        chk(k == 6 && !xfer_enable && fifo_level == 0, "R9 surplus dropped", {xfer_enable, fifo_level}, 0);
        clear_end();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        chk(!xfer_enable && byte_count == 0 && fifo_level == 0, "R1 reset state", byte_count, 0);
        chk(status == '0 && !card_rx_ready && !card_tx_valid, "R1 reset status", status, 0);

        host_push_valid = 1'b1; host_push_data = 32'hDEADBEEF;
        tick();
        host_push_valid = 1'b0;
        chk(fifo_level == 0, "R11 push ignored at zero count", fifo_level, 0);
        host_pop_req = 1'b1;
        chk(host_pop_data == 0, "R11 empty pop data", host_pop_data, 0);
        tick();
        host_pop_req = 1'b0;
        chk(fifo_level == 0, "R11 empty pop level", fifo_level, 0);

        for (int len = 0; len <= 40; len++) run_read(len, len % 2 == 1, 0);
        for (int len = 0; len <= 40; len++) run_write(len, len % 2 == 1);
        run_read(80, 1'b0, 100);
        underrun_case();

        summary();
        $finish;
    end

endmodule